// File: doc/BRIEF.md
# Interrupt Cause Register with Acknowledge and Masking

This block holds the interrupt-cause byte of a network controller's system control block and drives one level-sensitive interrupt line toward the host. The controller's internal units raise one-cycle event pulses, one per cause bit. Each pulse sets the matching cause bit, and the bit stays set until host software clears it. The host reads the cause byte and the mask byte on always-visible outputs. It writes one data byte through a single write port. A select input steers that byte either to the acknowledge function or to the mask register.

The mask byte has three kinds of field. The upper four bits each disable one upper cause. Bit 0 is a global gate for the line. Bit 1 is a strobe that raises a software cause. The line is a register. It is evaluated again after every cycle that sets a cause or writes the mask. An acknowledge can only drop the line, and only when the acknowledge empties the cause byte.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset, `cause_o` is 0x00, `mask_o` is 0x00 and `irq_o` is low.
- R2: A pulse on `event_i` bit k sets cause bit k at the next clock edge for k in {7,6,5,4,3,2,0}. A pulse on bit 1, which is not a cause, leaves the cause byte unchanged. Cause bits are 0x80 command done, 0x40 frame received, 0x20 command unit left active, 0x10 receiver not ready, 0x08 management cycle done, 0x04 software request, 0x01 pause.
- R3: A write with `wr_sel_i`=0 (acknowledge) clears every cause bit written as 1 and leaves the others unchanged.
- R4: If an event sets a bit and an acknowledge clears the same bit in the same cycle, the bit remains set.
- R5: The effective cause is cause AND (NOT mask OR 0x0F). After a cycle with an event or a mask write, `irq_o` is high when the effective cause is nonzero and mask bit 0 is clear.
- R6: When mask bit 0 is set, `irq_o` is low after any event or mask write, whatever causes are pending.
- R7: An acknowledge without an event or mask write drops `irq_o` when the cause byte becomes zero. Otherwise `irq_o` keeps its value, even if only masked causes remain.
- R8: A write with `wr_sel_i`=1 (mask) and data bit 1 set raises cause 0x04. Mask bit 1 always reads back 0.
- R9: A mask write re-evaluates the line. Unmasking a pending upper cause raises `irq_o`, and masking it lowers `irq_o`.
- R10: Mask bits 3:2 have no effect. The causes 0x08, 0x04 and 0x01 raise the line even when every upper mask bit is set.
- R11: `irq_o` changes only in the cycle after an event, an acknowledge write or a mask write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| event_i | input | 8 | One-cycle cause pulses, one bit per cause |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 1 | 0 selects acknowledge, 1 selects the mask register |
| wr_data_i | input | 8 | Host write data |
| cause_o | output | 8 | Current cause byte |
| mask_o | output | 8 | Current mask byte |
| irq_o | output | 1 | Level interrupt line, active high |

## Verification
Every result is registered. The cause byte, the mask byte and the line therefore all reflect a stimulus on the first clock edge after it is driven. The bench drives each stimulus on the falling edge. In the same half cycle it pushes the value the model predicts into a queue. A monitor pops that value one time unit after the next rising edge, so every comparison lands exactly one cycle after its stimulus. Idle cycles are also pushed and compared, which shows that the line holds when nothing re-evaluates it.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int CAUSE_W = 8;
  typedef logic [CAUSE_W-1:0] cause_t;

  // bits that exist as causes (bit 1 has no cause)
  localparam cause_t CAUSE_IMPL   = 8'hFD;
  // low causes that per-bit mask cannot suppress
  localparam cause_t CAUSE_UNMASK = 8'h0F;
  // cause raised by the software request strobe
  localparam cause_t CAUSE_SWI    = 8'h04;
  // mask byte field positions
  localparam int MASK_GLOBAL_BIT = 0;
  localparam int MASK_SWI_BIT    = 1;

  function automatic cause_t eff_cause(input cause_t cause, input cause_t mask);
    return cause & (~mask | CAUSE_UNMASK);
  endfunction
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_cause_pkg::*;
#(
  parameter int W = CAUSE_W,
  parameter int SWI_BIT = MASK_SWI_BIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] mask_d,
  output logic [W-1:0] mask_q,
  output logic         swi_req
);
  localparam logic [W-1:0] KEEP = ~(W'(1) << SWI_BIT);

  always_comb begin
    mask_d  = mask_q;
    swi_req = 1'b0;
    if (mask_we) begin
      mask_d  = wr_data & KEEP;
      swi_req = wr_data[SWI_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end

  // R8
  swi_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q[SWI_BIT] == 1'b0));
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_cause_pkg::*;
#(
  parameter int W = CAUSE_W,
  parameter logic [W-1:0] IMPL = CAUSE_IMPL,
  parameter logic [W-1:0] SWI_CAUSE = CAUSE_SWI
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] event_pulse,
  input  logic         swi_req,
  input  logic         ack_we,
  input  logic [W-1:0] ack_data,
  output logic [W-1:0] status_d,
  output logic [W-1:0] status_q,
  output logic         set_any
);
  logic [W-1:0] set_vec;
  logic [W-1:0] clr_vec;

  always_comb begin
    set_vec = (event_pulse | (swi_req ? SWI_CAUSE : '0)) & IMPL;
    clr_vec = ack_we ? ack_data : '0;
    set_any = |set_vec;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic bit_en;
      always_comb begin
        // set after clear: an event in the same cycle wins
        status_d[i] = (status_q[i] & ~clr_vec[i]) | set_vec[i];
        bit_en      = set_vec[i] | clr_vec[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      status_q[i] <= 1'b0;
        else if (bit_en) status_q[i] <= status_d[i];
      end
    end else begin : g_none
      always_comb status_d[i] = 1'b0;
      assign status_q[i] = 1'b0;
    end
  end

  // R3
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && !set_any) |=> ((status_q & $past(ack_data)) == '0));
  // R4
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_any |=> ((status_q & $past(set_vec)) == $past(set_vec)));
  // R2
  no_ack_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_we |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/irq_line_eval.sv
module irq_line_eval
  import irq_cause_pkg::*;
#(
  parameter int W = CAUSE_W,
  parameter int GLOBAL_BIT = MASK_GLOBAL_BIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         eval,
  input  logic         ack_we,
  input  logic [W-1:0] status_d,
  input  logic [W-1:0] mask_d,
  output logic         irq_q
);
  logic irq_d;
  logic irq_en;

  always_comb begin
    irq_d  = irq_q;
    irq_en = eval | ack_we;
    if (eval)
      irq_d = (|eff_cause(status_d, mask_d)) & ~mask_d[GLOBAL_BIT];
    else if (ack_we)
      irq_d = irq_q & (|status_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end

  // R6
  global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && mask_d[GLOBAL_BIT]) |=> !irq_q);
  // R7
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && !eval && (status_d == '0)) |=> !irq_q);
  // R7
  ack_no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && !eval && !irq_q) |=> !irq_q);
  // R11
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval && !ack_we) |=> $stable(irq_q));
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int W = CAUSE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] event_i,
  input  logic         wr_en_i,
  input  logic         wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] cause_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic         mask_we;
  logic         ack_we;
  logic         swi_req;
  logic         set_any;
  logic         eval;
  logic [W-1:0] mask_d;
  logic [W-1:0] status_d;

  always_comb begin
    mask_we = wr_en_i & wr_sel_i;
    ack_we  = wr_en_i & ~wr_sel_i;
    eval    = set_any | mask_we;
  end

  irq_mask_reg #(.W(W)) u_mask (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .wr_data(wr_data_i),
    .mask_d(mask_d), .mask_q(mask_o), .swi_req(swi_req)
  );

  irq_status_reg #(.W(W)) u_status (
    .clk(clk), .rst_n(rst_n), .event_pulse(event_i), .swi_req(swi_req),
    .ack_we(ack_we), .ack_data(wr_data_i), .status_d(status_d),
    .status_q(cause_o), .set_any(set_any)
  );

  irq_line_eval #(.W(W)) u_line (
    .clk(clk), .rst_n(rst_n), .eval(eval), .ack_we(ack_we),
    .status_d(status_d), .mask_d(mask_d), .irq_q(irq_o)
  );

  // R8
  swi_sets_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && wr_data_i[MASK_SWI_BIT]) |=> cause_o[2]);
  // R5
  line_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cause_o != '0));
endmodule

// File: tb/irq_cause_ctrl_test.sv
module irq_cause_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] event_i;
  logic       wr_en_i;
  logic       wr_sel_i;
  logic [7:0] wr_data_i;
  logic [7:0] cause_o;
  logic [7:0] mask_o;
  logic       irq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cause_ctrl uut (
    .clk(clk), .rst_n(rst_n), .event_i(event_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .cause_o(cause_o),
    .mask_o(mask_o), .irq_o(irq_o)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [16:0] exp_q[$];
  string       tag_q[$];

  logic [7:0] m_st, m_mk;
  logic       m_irq;

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: cause/mask/irq actual %h/%h/%b expected %h/%h/%b",
               tag, act[16:9], act[8:1], act[0], exp[16:9], exp[8:1], exp[0]);
    end
  endtask

  // driver: one cycle of stimulus, model update, push expectation
  task automatic step(input logic [7:0] ev, input logic we, input logic sel,
                      input logic [7:0] d, input string tag);
    logic [7:0] set, ack, st_n, mk_n;
    logic       ev_mask;
    @(negedge clk);
    event_i = ev; wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
    set = ev & 8'hFD;
    if (we && sel && d[1]) set = set | 8'h04;
    ack = (we && !sel) ? d : 8'h00;
    st_n = (m_st & ~ack) | set;
    mk_n = (we && sel) ? (d & 8'hFD) : m_mk;
    ev_mask = (set != 0) || (we && sel);
    if (ev_mask)
      m_irq = ((st_n & (~mk_n | 8'h0F)) != 0) && !mk_n[0];
    else if (we && !sel)
      m_irq = m_irq && (st_n != 0);
    m_st = st_n; m_mk = mk_n;
    exp_q.push_back({m_st, m_mk, m_irq});
    tag_q.push_back(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {cause_o, mask_o, irq_o}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; event_i = 0; wr_en_i = 0; wr_sel_i = 0; wr_data_i = 0;
    m_st = 0; m_mk = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    #1 check("R1 reset", {cause_o, mask_o, irq_o}, 17'h0);
    @(negedge clk) rst_n = 1'b1;

    step(8'h80, 0, 0, 8'h00, "R2 R5 cmd done raises line");
    step(8'h00, 1, 0, 8'h80, "R3 R7 ack to zero drops line");
    step(8'h02, 0, 0, 8'h00, "R2 bit1 event ignored");
    step(8'h41, 0, 0, 8'h00, "R2 two causes at once");
    step(8'h00, 1, 0, 8'h40, "R3 partial ack keeps other bit");
    step(8'h00, 1, 0, 8'h01, "R7 ack to zero");
    step(8'h00, 1, 1, 8'h80, "R9 mask upper bit");
    step(8'h80, 0, 0, 8'h00, "R5 masked cause no line");
    step(8'h00, 1, 1, 8'h00, "R9 unmask raises line");
    step(8'h00, 1, 1, 8'h80, "R9 mask again lowers line");
    step(8'h00, 1, 1, 8'hFC, "R10 all upper masked");
    step(8'h08, 0, 0, 8'h00, "R10 mgmt cause unmaskable");
    step(8'h00, 1, 0, 8'h08, "R7 masked cause remains line held");
    step(8'h00, 1, 0, 8'h80, "R7 ack to zero");
    step(8'h00, 1, 1, 8'h01, "R6 global mask");
    step(8'h10, 0, 0, 8'h00, "R6 event under global mask");
    step(8'h00, 0, 0, 8'h00, "R11 idle holds");
    step(8'h00, 1, 1, 8'h00, "R9 global unmask raises");
    step(8'h00, 1, 0, 8'hFF, "R7 ack all");
    step(8'h00, 1, 1, 8'h02, "R8 software request");
    step(8'h00, 0, 0, 8'h00, "R11 idle holds");
    step(8'h40, 1, 0, 8'hFF, "R4 event wins over ack");
    step(8'h00, 1, 0, 8'h00, "R7 ack of zero no change");
    step(8'h00, 1, 1, 8'hF1, "R6 global mask with causes");
    step(8'h00, 1, 0, 8'hFF, "R7 ack all under mask");
    step(8'h00, 1, 1, 8'hF0, "R10 global clear nothing pending");
    step(8'h01, 0, 0, 8'h00, "R10 pause cause unmaskable");
    step(8'h00, 0, 0, 8'h00, "R11 idle holds");

    @(negedge clk);
    event_i = 0; wr_en_i = 0;
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule